// File: doc/BRIEF.md
# Package Power State Coordinator

This block watches the idle-state codes reported by one or two processor cores and derives a single package-level power state from them. The possible states are running, stop-granted, deeper sleep, or quiet idle. It also raises a deeper-sleep request toward the platform's power logic when every core is parked in its deepest idle state and software has allowed it.

A stop-clock request from the platform arrives asynchronously. Once it has been synchronized, the block starts an acknowledge handshake on the bus side. After the response, it grants the stop to every core that was running at the time of the request. Cores already sitting in a deep idle state are left where they are. The grant happens when the eligible cores report ready, and never later than a bounded number of clocks after the response. When the request is withdrawn, the block releases the grant. It then hands each granted core the state code it held before, together with a one-cycle restore strobe.

Top module: `pkg_pwr_coord`

## Requirements
- R1: Out of reset, the outputs are as follows. Package state is 0 (running). The deeper-sleep request, acknowledge request, late flag, all stop-grant bits and all restore bits are low.
- R2: Core codes are 3 bits per core, with core i at bits [3i+2:3i]: 0 run, 1 halt, 2 wait, 3 C2, 4 C3, 5 C4. Whenever any core reports 0, 1 or 2 and no stop is granted, the package state is 0 (running) one cycle later.
- R3: The configuration write port takes two bits: bit 1 enables deeper sleep and bit 0 enables single-core coordination. With two cores, the deeper-sleep request is high only while both cores report 5 and bit 1 is set. The package state is then 2.
- R4: With one core reporting 5 and bit 1 set, the deeper-sleep request stays low unless bit 0 is also set.
- R5: The deeper-sleep request falls on the first clock edge after any core's code changes away from 5.
- R6: The stop-clock input passes through a two-stage synchronizer. The acknowledge request rises on the third clock edge after the input rises.
- R7: The acknowledge request stays high until the response input is sampled high. It is low from the following cycle.
- R8: A core reporting 0, 1 or 2 when the synchronized stop request is first seen becomes eligible. Eligible cores get their stop-grant bit as soon as all of them report ready after the response. The package state is then 1.
- R9: A core reporting 3, 4 or 5 at that moment never gets a stop-grant bit during that request.
- R10: If the eligible cores are not all ready, the grant is forced exactly GRANT_LIMIT edges after the response edge and the late flag is set. The flag holds until the next stop request is accepted.
- R11: On release, all stop-grant bits fall on the third edge after the input falls. In that same cycle, each granted core gets a one-cycle restore pulse, and the resume-state output carries its saved code.
- R12: When no core runs, no stop is granted and no deeper-sleep request is raised, the package state is 3 (quiet).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| core_state | input | 3*NUM_CORES | Per-core idle-state codes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 1 deeper-sleep enable, bit 0 single-core coordination enable |
| stop_clk_req | input | 1 | Asynchronous stop-clock request, active high |
| sg_ack_req | output | 1 | Stop-grant acknowledge cycle request |
| sg_ack_rsp | input | 1 | Response phase of the acknowledge cycle |
| core_sg_ready | input | NUM_CORES | Per-core readiness to enter stop-grant |
| core_stop_grant | output | NUM_CORES | Per-core stop-grant indication |
| core_restore | output | NUM_CORES | One-cycle restore strobe per core |
| core_resume_state | output | 3*NUM_CORES | Saved code each core returns to |
| grant_late | output | 1 | Grant was forced at the clock bound |
| pkg_state | output | 2 | 0 running, 1 stop-grant, 2 deeper sleep, 3 quiet |
| deeper_sleep_req | output | 1 | Deeper-sleep request |

## Verification
The bench builds two instances. The first has two cores and GRANT_LIMIT of 6. With that short bound, the forced late grant falls a few cycles after the response, and the bench can check it on the exact edge. The second has one core and makes the single-core coordination gate reachable. Together, the two instances exercise mixed eligibility, where one core is granted and one is skipped, and the case where no core is eligible at all.

// File: rtl/pwr_coord_pkg.sv
package pwr_coord_pkg;

  localparam int CS_W = 3;

  typedef enum logic [2:0] {
    CS_RUN     = 3'd0,
    CS_HALT    = 3'd1,
    CS_WAIT    = 3'd2,
    CS_C2      = 3'd3,
    CS_C3      = 3'd4,
    CS_C4      = 3'd5
  } core_cstate_e;

  typedef enum logic [1:0] {
    PKG_RUNNING    = 2'd0,
    PKG_STOP_GRANT = 2'd1,
    PKG_DEEPER     = 2'd2,
    PKG_QUIET      = 2'd3
  } pkg_state_e;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACK     = 2'd1,
    PH_WAIT    = 2'd2,
    PH_GRANTED = 2'd3
  } sg_phase_e;

  typedef struct packed {
    logic deep_en;
    logic coord_en;
  } coord_cfg_t;

  // A core counts as running in the active, halt and wait codes.
  function automatic logic cs_is_active(input logic [CS_W-1:0] code);
    return (code == CS_RUN) || (code == CS_HALT) || (code == CS_WAIT);
  endfunction

  function automatic logic cs_is_c4(input logic [CS_W-1:0] code);
    return code == CS_C4;
  endfunction

endpackage

// File: rtl/pwc_stop_sync.sv
module pwc_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pwc_grant_ctrl.sv
module pwc_grant_ctrl
  import pwr_coord_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int GRANT_LIMIT = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stop_sync,
  input  logic [CS_W*NUM_CORES-1:0] core_q,
  input  logic                      ack_rsp,
  input  logic [NUM_CORES-1:0]      sg_ready,
  output logic                      ack_req,
  output logic [NUM_CORES-1:0]      sg_granted,
  output logic [NUM_CORES-1:0]      restore,
  output logic [CS_W*NUM_CORES-1:0] resume_state,
  output logic                      late,
  output logic                      granted
);
  localparam int CNT_W = $clog2(GRANT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GRANT_LIMIT - 1);

  sg_phase_e                 phase;
  logic [CNT_W-1:0]          cnt;
  logic [NUM_CORES-1:0]      eligible;
  logic [NUM_CORES-1:0]      elig_now;
  logic [CS_W*NUM_CORES-1:0] saved;
  logic [NUM_CORES-1:0]      restore_q;
  logic                      late_q;

  // Named events for the checks below.
  logic ready_ok;
  logic limit_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CORES; gi++) begin : g_elig
      assign elig_now[gi] = cs_is_active(core_q[gi*CS_W +: CS_W]);
    end
  endgenerate

  assign ready_ok  = &(sg_ready | ~eligible);
  assign limit_hit = (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      eligible  <= '0;
      saved     <= '0;
      restore_q <= '0;
      late_q    <= 1'b0;
    end else begin
      restore_q <= '0;
      unique case (phase)
        PH_IDLE: begin
          if (stop_sync) begin
            phase    <= PH_ACK;
            eligible <= elig_now;
            saved    <= core_q;
            late_q   <= 1'b0;
          end
        end
        PH_ACK: begin
          if (!stop_sync) begin
            phase <= PH_IDLE;
          end else if (ack_rsp) begin
            phase <= PH_WAIT;
            cnt   <= '0;
          end
        end
        PH_WAIT: begin
          if (!stop_sync) begin
            phase <= PH_IDLE;
          end else if (ready_ok) begin
            phase <= PH_GRANTED;
          end else if (limit_hit) begin
            phase  <= PH_GRANTED;
            late_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GRANTED: begin
          if (!stop_sync) begin
            phase     <= PH_IDLE;
            restore_q <= eligible;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign ack_req      = (phase == PH_ACK);
  assign granted      = (phase == PH_GRANTED);
  assign sg_granted   = eligible & {NUM_CORES{granted}};
  assign restore      = restore_q;
  assign resume_state = saved;
  assign late         = late_q;

  // R6: a newly seen stop request opens the acknowledge cycle next edge
  a_r6_ack_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_sync) && phase == PH_IDLE) |=> ack_req);

  // R7: no response, request still present -> acknowledge held
  a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_rsp && stop_sync) |=> ack_req);

  // R10: the wait counter never passes the bound
  a_r10_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT) |-> (cnt < CNT_W'(GRANT_LIMIT)));

  // R11: restore strobe lasts one cycle
  a_r11_restore_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|restore_q) |=> (restore_q == '0));

  generate
    for (gi = 0; gi < NUM_CORES; gi++) begin : g_chk
      // R9: only cores that were running when latched may be granted
      a_r9_grant_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        sg_granted[gi] |-> cs_is_active(saved[gi*CS_W +: CS_W]));
    end
  endgenerate
endmodule

// File: rtl/pwc_pkg_eval.sv
module pwc_pkg_eval
  import pwr_coord_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic [CS_W*NUM_CORES-1:0] core_q,
  input  coord_cfg_t                cfg,
  input  logic                      granted,
  output logic [1:0]                pkg_state,
  output logic                      dsr
);
  localparam bit MULTI = (NUM_CORES > 1);

  logic       any_active;
  logic       all_c4;
  pkg_state_e st;

  always_comb begin
    any_active = 1'b0;
    all_c4     = 1'b1;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (cs_is_active(core_q[i*CS_W +: CS_W])) any_active = 1'b1;
      if (!cs_is_c4(core_q[i*CS_W +: CS_W]))    all_c4     = 1'b0;
    end
  end

  assign dsr = cfg.deep_en && all_c4 && (MULTI || cfg.coord_en);

  always_comb begin
    if (granted)         st = PKG_STOP_GRANT;
    else if (any_active) st = PKG_RUNNING;
    else if (dsr)        st = PKG_DEEPER;
    else                 st = PKG_QUIET;
  end

  assign pkg_state = st;
endmodule

// File: rtl/pkg_pwr_coord.sv
module pkg_pwr_coord
  import pwr_coord_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int GRANT_LIMIT = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3*NUM_CORES-1:0]    core_state,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_wdata,
  input  logic                      stop_clk_req,
  output logic                      sg_ack_req,
  input  logic                      sg_ack_rsp,
  input  logic [NUM_CORES-1:0]      core_sg_ready,
  output logic [NUM_CORES-1:0]      core_stop_grant,
  output logic [NUM_CORES-1:0]      core_restore,
  output logic [3*NUM_CORES-1:0]    core_resume_state,
  output logic                      grant_late,
  output logic [1:0]                pkg_state,
  output logic                      deeper_sleep_req
);
  logic [CS_W*NUM_CORES-1:0] core_q;
  coord_cfg_t                cfg_q;
  logic                      stop_sync;
  logic                      granted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      cfg_q  <= '0;
    end else begin
      core_q <= core_state;
      if (cfg_we) cfg_q <= coord_cfg_t'(cfg_wdata);
    end
  end

  pwc_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (stop_clk_req),
    .sync_out (stop_sync)
  );

  pwc_grant_ctrl #(.NUM_CORES(NUM_CORES), .GRANT_LIMIT(GRANT_LIMIT)) u_grant (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_sync    (stop_sync),
    .core_q       (core_q),
    .ack_rsp      (sg_ack_rsp),
    .sg_ready     (core_sg_ready),
    .ack_req      (sg_ack_req),
    .sg_granted   (core_stop_grant),
    .restore      (core_restore),
    .resume_state (core_resume_state),
    .late         (grant_late),
    .granted      (granted)
  );

  pwc_pkg_eval #(.NUM_CORES(NUM_CORES)) u_eval (
    .core_q    (core_q),
    .cfg       (cfg_q),
    .granted   (granted),
    .pkg_state (pkg_state),
    .dsr       (deeper_sleep_req)
  );

  // Input-side views for the checks.
  logic in_all_c4;
  logic in_any_active;
  always_comb begin
    in_all_c4     = 1'b1;
    in_any_active = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (core_state[i*3 +: 3] != 3'd5) in_all_c4 = 1'b0;
      if (core_state[i*3 +: 3] <= 3'd2) in_any_active = 1'b1;
    end
  end

  // R2: a running core keeps the package out of idle states
  a_r2_running_wins: assert property (@(posedge clk) disable iff (!rst_n)
    in_any_active |=> (pkg_state == PKG_RUNNING || pkg_state == PKG_STOP_GRANT));

  // R3: the request is only ever seen after unanimous C4 at the pins
  a_r3_needs_all_c4: assert property (@(posedge clk) disable iff (!rst_n)
    deeper_sleep_req |-> $past(in_all_c4));

  // R5: a core leaving C4 removes the request on the next edge
  a_r5_dsr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (deeper_sleep_req && !in_all_c4) |=> !deeper_sleep_req);
endmodule

// File: tb/pkg_pwr_coord_tb.sv
module pkg_pwr_coord_tb;
  localparam int LIM = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] core_state = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = '0;
  logic       stop_in = 1'b0;
  logic       ack_rsp = 1'b0;
  logic [1:0] ready = '0;
  logic       ack_req;
  logic [1:0] sg;
  logic [1:0] rst_pulse;
  logic [5:0] resume;
  logic       late;
  logic [1:0] pkg;
  logic       dsr;

  logic [2:0] s_core = '0;
  logic       s_we = 1'b0;
  logic [1:0] s_wdata = '0;
  logic       s_ack_req;
  logic [0:0] s_sg;
  logic [0:0] s_rst;
  logic [2:0] s_resume;
  logic       s_late;
  logic [1:0] s_pkg;
  logic       s_dsr;

  always #2 clk = ~clk;

  pkg_pwr_coord #(.NUM_CORES(2), .GRANT_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_state(core_state), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .stop_clk_req(stop_in), .sg_ack_req(ack_req),
    .sg_ack_rsp(ack_rsp), .core_sg_ready(ready), .core_stop_grant(sg),
    .core_restore(rst_pulse), .core_resume_state(resume), .grant_late(late),
    .pkg_state(pkg), .deeper_sleep_req(dsr)
  );

  pkg_pwr_coord #(.NUM_CORES(1), .GRANT_LIMIT(LIM)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .core_state(s_core), .cfg_we(s_we),
    .cfg_wdata(s_wdata), .stop_clk_req(1'b0), .sg_ack_req(s_ack_req),
    .sg_ack_rsp(1'b0), .core_sg_ready(1'b1), .core_stop_grant(s_sg),
    .core_restore(s_rst), .core_resume_state(s_resume), .grant_late(s_late),
    .pkg_state(s_pkg), .deeper_sleep_req(s_dsr)
  );

  typedef struct {
    int    cyc;
    int    kind;
    int    expv;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(int kind);
    case (kind)
      0: return int'(pkg);
      1: return int'(dsr);
      2: return int'(sg);
      3: return int'(ack_req);
      4: return int'(late);
      5: return int'(rst_pulse);
      6: return int'(resume);
      7: return int'(s_dsr);
      8: return int'(s_pkg);
      default: return -1;
    endcase
  endfunction

  // Driver side: schedule an expected value d clock edges from now.
  task automatic expect_at(int d, int kind, int v, string req);
    exp_t e;
    int   pos;
    e.cyc = cyc + d; e.kind = kind; e.expv = v; e.req = req;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > e.cyc) begin pos = i; break; end
    end
    q.insert(pos, e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare due items shortly after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        int   got;
        e = q.pop_front();
        got = observe(e.kind);
        checks++;
        if (e.cyc != cyc || got != e.expv) begin
          errors++;
          $display("FAIL %s kind=%0d cyc=%0d actual=%0d expected=%0d",
                   e.req, e.kind, cyc, got, e.expv);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R1: reset values
    expect_at(0, 0, 0, "R1"); expect_at(0, 1, 0, "R1");
    expect_at(0, 2, 0, "R1"); expect_at(0, 3, 0, "R1");
    expect_at(0, 4, 0, "R1"); expect_at(0, 5, 0, "R1");
    tick(1);
    rst_n = 1'b1;
    tick(2);

    // R2: one core in wait, other in C4 -> running
    core_state = {3'd5, 3'd2};
    expect_at(1, 0, 0, "R2"); expect_at(1, 1, 0, "R2");
    tick(2);
    // R12: both in C3 -> quiet
    core_state = {3'd4, 3'd4};
    expect_at(1, 0, 3, "R12"); expect_at(1, 1, 0, "R12");
    tick(2);
    // R3: both C4 but deeper sleep disabled -> quiet, no request
    core_state = {3'd5, 3'd5};
    expect_at(1, 1, 0, "R3"); expect_at(1, 0, 3, "R3");
    tick(2);
    cfg_we = 1'b1; cfg_wdata = 2'b10;
    expect_at(1, 1, 1, "R3"); expect_at(1, 0, 2, "R3");
    tick(1);
    cfg_we = 1'b0;
    tick(2);
    // R5: core1 leaves C4 -> request falls next edge
    core_state = {3'd4, 3'd5};
    expect_at(1, 1, 0, "R5"); expect_at(1, 0, 3, "R5");
    tick(2);
    core_state = {3'd3, 3'd5};
    expect_at(1, 1, 0, "R3");
    tick(2);

    // R4: single core, C4 with only deep enable -> no request
    s_core = 3'd5; s_we = 1'b1; s_wdata = 2'b10;
    expect_at(1, 7, 0, "R4"); expect_at(1, 8, 3, "R4");
    tick(1);
    s_wdata = 2'b11;
    expect_at(1, 7, 1, "R4"); expect_at(1, 8, 2, "R4");
    tick(1);
    s_we = 1'b0;
    tick(2);

    // Stop sequence A: core0 running, core1 in C3
    core_state = {3'd4, 3'd0};
    ready = 2'b01;
    tick(2);
    stop_in = 1'b1;
    expect_at(2, 3, 0, "R6"); expect_at(3, 3, 1, "R6");
    tick(3);
    expect_at(1, 3, 1, "R7");
    tick(1);
    ack_rsp = 1'b1;
    expect_at(1, 3, 0, "R7"); expect_at(1, 2, 0, "R8");
    expect_at(2, 2, 1, "R8"); expect_at(2, 0, 1, "R8");
    expect_at(2, 4, 0, "R8");
    tick(1);
    ack_rsp = 1'b0;
    tick(4);
    // R9: core1 (C3 at latch) stays out of stop-grant
    expect_at(0, 2, 1, "R9");
    stop_in = 1'b0;
    expect_at(2, 2, 1, "R11"); expect_at(2, 5, 0, "R11");
    expect_at(3, 2, 0, "R11"); expect_at(3, 5, 1, "R11");
    expect_at(3, 6, 6'b100_000, "R11"); expect_at(3, 0, 0, "R11");
    expect_at(4, 5, 0, "R11");
    tick(6);

    // Stop sequence B: both running, never ready -> forced late grant
    core_state = {3'd0, 3'd1};
    ready = 2'b00;
    tick(2);
    stop_in = 1'b1;
    tick(3);
    expect_at(0, 3, 1, "R10");
    ack_rsp = 1'b1;
    expect_at(LIM, 2, 0, "R10"); expect_at(LIM, 4, 0, "R10");
    expect_at(LIM + 1, 2, 3, "R10"); expect_at(LIM + 1, 4, 1, "R10");
    tick(1);
    ack_rsp = 1'b0;
    tick(LIM + 2);
    stop_in = 1'b0;
    expect_at(3, 5, 3, "R11"); expect_at(3, 6, 6'b000_001, "R11");
    expect_at(4, 4, 1, "R10");
    tick(6);

    // Stop sequence C: both in C4, none eligible
    core_state = {3'd5, 3'd5};
    tick(2);
    stop_in = 1'b1;
    tick(3);
    expect_at(0, 4, 0, "R10");
    ack_rsp = 1'b1;
    expect_at(2, 2, 0, "R9"); expect_at(2, 0, 1, "R8");
    tick(1);
    ack_rsp = 1'b0;
    tick(3);
    stop_in = 1'b0;
    expect_at(3, 5, 0, "R11"); expect_at(3, 2, 0, "R11");
    tick(6);

    while (q.size() > 0) tick(1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule